// File: doc/BRIEF.md
# Error Signaling Aggregator

The block gathers single-cycle or level error indications from many on-chip sources (for example the single-error flags of two independent RAM ports) onto numbered channels. A rising edge on a channel's source input latches a sticky status flag for that channel. Software clears flags by writing ones to their bit positions in the status register.

Each channel has two independent responses. The first is a CPU interrupt. The second is an active-low external error pin. Each response has its own enable register. The interrupt is the OR over all channels of flag AND interrupt-enable. The pin is pulled low while any channel whose pin-enable is set has its flag set.

The register interface is a small word-addressed port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `err_aggregator`

## Requirements
- R1: After reset, every status flag and both enable registers read 0, `irq_o` is 0 and `err_pin_no` is 1.
- R2: A 0-to-1 transition on `err_i[k]` sampled at a clock edge sets status bit k at that edge. A source held high does not set the bit again after it has been cleared.
- R3: Status bits are set regardless of the enable registers, including when both enables of the channel are 0.
- R4: A write to address 0 (status) clears every status bit whose `wdata_i` bit is 1. Bits written with 0 keep their value. For example, writing 0x14000000 clears channels 26 and 28 only.
- R5: If a rising edge on channel k and a clear of bit k occur at the same clock edge, bit k ends up set.
- R6: `irq_o` is 1 exactly when some channel has both its status bit and its interrupt-enable bit (address 1) set.
- R7: `err_pin_no` is 0 exactly when some channel has both its status bit and its pin-enable bit (address 2) set.
- R8: Writes to address 1 or 2 replace the whole enable register, and that value reads back at the same address. Reads of address 3 return 0, and writes to address 3 change nothing.
- R9: The two responses are independent per channel. A channel can drive only the interrupt, only the pin, both, or neither.
- R10: Status bits are sticky. A set bit stays set until a write clears it, whatever its source input does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| err_i | input | NUM_CH | Error source inputs, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address (0 status, 1 interrupt enable, 2 pin enable) |
| wdata_i | input | NUM_CH | Write data |
| rdata_o | output | NUM_CH | Read data for `addr_i` |
| irq_o | output | 1 | CPU interrupt request |
| err_pin_no | output | 1 | External error pin, active low |

## Verification
The bench builds the block with the default 32 channels. At that width, channels 26 and 28 exist and can be cleared together with 0x14000000. It also makes the upper half of the word reachable, so a mistake in the reduction trees or the clear mask shows up there and not only in the low bits. Directed sequences cover each ordering of set, clear and enable changes. A random phase then drives all three registers and the sources against a behavioural model every cycle.

// File: rtl/err_agg_pkg.sv
package err_agg_pkg;
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_IRQ_EN = 2'd1,
    REG_PIN_EN = 2'd2,
    REG_RSVD   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/err_agg_edge.sv
module err_agg_edge #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] src_i,
  output logic [NUM_CH-1:0] rise_o
);
  logic [NUM_CH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= src_i;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign rise_o[g] = src_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/err_agg_status.sv
module err_agg_status #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] flag_o
);
  logic [NUM_CH-1:0] flag_q;

  // set dominates clear in the same cycle
  for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[g] <= 1'b0;
      else if (set_i[g])  flag_q[g] <= 1'b1;
      else if (clr_i[g])  flag_q[g] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/err_agg_cfg.sv
module err_agg_cfg
  import err_agg_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic [NUM_CH-1:0] flag_i,
  output logic [NUM_CH-1:0] clr_o,
  output logic [NUM_CH-1:0] irq_en_o,
  output logic [NUM_CH-1:0] pin_en_o,
  output logic [NUM_CH-1:0] rdata_o
);
  reg_sel_e          sel;
  logic [NUM_CH-1:0] irq_en_q, pin_en_q;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= '0;
      pin_en_q <= '0;
    end else if (wr_en_i) begin
      if (sel == REG_IRQ_EN) irq_en_q <= wdata_i;
      if (sel == REG_PIN_EN) pin_en_q <= wdata_i;
    end
  end

  assign clr_o = (wr_en_i && sel == REG_STATUS) ? wdata_i : '0;

  always_comb begin
    unique case (sel)
      REG_STATUS: rdata_o = flag_i;
      REG_IRQ_EN: rdata_o = irq_en_q;
      REG_PIN_EN: rdata_o = pin_en_q;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_en_o = irq_en_q;
  assign pin_en_o = pin_en_q;
endmodule

// File: rtl/err_agg_resp.sv
module err_agg_resp #(
  parameter int unsigned NUM_CH     = 32,
  parameter bit          ACTIVE_LOW = 1'b0
) (
  input  logic [NUM_CH-1:0] flag_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic              out_o
);
  logic any_hit;

  assign any_hit = |(flag_i & en_i);

  if (ACTIVE_LOW) begin : g_low
    assign out_o = ~any_hit;
  end else begin : g_high
    assign out_o = any_hit;
  end
endmodule

// File: rtl/err_aggregator.sv
module err_aggregator #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] err_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] rdata_o,
  output logic              irq_o,
  output logic              err_pin_no
);
  logic [NUM_CH-1:0] rise_w, clr_w, flag_w, irq_en_w, pin_en_w;

  err_agg_edge #(.NUM_CH(NUM_CH)) edge_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (err_i),
    .rise_o(rise_w)
  );

  err_agg_status #(.NUM_CH(NUM_CH)) status_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (rise_w),
    .clr_i (clr_w),
    .flag_o(flag_w)
  );

  err_agg_cfg #(.NUM_CH(NUM_CH)) cfg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .flag_i  (flag_w),
    .clr_o   (clr_w),
    .irq_en_o(irq_en_w),
    .pin_en_o(pin_en_w),
    .rdata_o (rdata_o)
  );

  err_agg_resp #(.NUM_CH(NUM_CH), .ACTIVE_LOW(1'b0)) irq_resp_i (
    .flag_i(flag_w),
    .en_i  (irq_en_w),
    .out_o (irq_o)
  );

  err_agg_resp #(.NUM_CH(NUM_CH), .ACTIVE_LOW(1'b1)) pin_resp_i (
    .flag_i(flag_w),
    .en_i  (pin_en_w),
    .out_o (err_pin_no)
  );
endmodule

// File: rtl/err_aggregator_chk.sv
module err_aggregator_chk #(
  parameter int unsigned NUM_CH = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] err_i,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [NUM_CH-1:0] wdata_i,
  input logic              irq_o,
  input logic              err_pin_no,
  input logic [NUM_CH-1:0] flag_w,
  input logic [NUM_CH-1:0] irq_en_w,
  input logic [NUM_CH-1:0] pin_en_w
);
  logic [NUM_CH-1:0] src_seen_q, edge_now, clr_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_seen_q <= '0;
    else         src_seen_q <= err_i;
  end

  assign edge_now = err_i & ~src_seen_q;
  assign clr_now  = (wr_en_i && addr_i == 2'd0) ? wdata_i : '0;

  assert_edge_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_now != '0) |=> ((flag_w & $past(edge_now)) == $past(edge_now)));

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edge_now & clr_now) != '0) |=> ((flag_w & $past(edge_now & clr_now)) == $past(edge_now & clr_now)));

  assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_now != '0) |=> ((flag_w & $past(clr_now & ~edge_now)) == '0));

  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_w & $past(flag_w & ~clr_now)) == $past(flag_w & ~clr_now)));

  assert_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((flag_w & irq_en_w) != '0));

  assert_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pin_no == ((flag_w & pin_en_w) == '0));

  assert_irq_en_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1) |=> (irq_en_w == $past(wdata_i)));

  assert_rsvd_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd3) |=> ($stable(irq_en_w) && $stable(pin_en_w)));
endmodule

bind err_aggregator err_aggregator_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .err_i     (err_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .irq_o     (irq_o),
  .err_pin_no(err_pin_no),
  .flag_w    (flag_w),
  .irq_en_w  (irq_en_w),
  .pin_en_w  (pin_en_w)
);

// File: tb/err_aggregator_tb_top.sv
module err_aggregator_tb_top;
  localparam int unsigned NUM_CH = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_CH-1:0] err = '0;
  logic              we = 1'b0;
  logic [1:0]        addr = 2'd0;
  logic [NUM_CH-1:0] wdata = '0;
  logic [NUM_CH-1:0] rdata;
  logic              irq, pin_n;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  err_aggregator #(.NUM_CH(NUM_CH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .err_i(err), .wr_en_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .err_pin_no(pin_n)
  );

  // behavioural reference
  logic [NUM_CH-1:0] m_stat, m_ien, m_pen, m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat <= '0; m_ien <= '0; m_pen <= '0; m_prev <= '0;
    end else begin
      logic [NUM_CH-1:0] nxt;
      nxt = m_stat;
      if (we && addr == 2'd0) nxt = nxt & ~wdata;
      for (int i = 0; i < NUM_CH; i++)
        if (err[i] && !m_prev[i]) nxt[i] = 1'b1;
      m_stat <= nxt;
      m_prev <= err;
      if (we && addr == 2'd1) m_ien <= wdata;
      if (we && addr == 2'd2) m_pen <= wdata;
    end
  end

  function automatic logic [NUM_CH-1:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_stat;
      2'd1: return m_ien;
      2'd2: return m_pen;
      default: return '0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [NUM_CH-1:0] act,
                       input logic [NUM_CH-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, between negedge drive and next posedge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(irq === ((m_stat & m_ien) != '0), "R6 irq", {31'd0, irq}, {31'd0, (m_stat & m_ien) != '0});
      check(pin_n === ((m_stat & m_pen) == '0), "R7 pin", {31'd0, pin_n}, {31'd0, (m_stat & m_pen) == '0});
      check(rdata === m_read(addr), "R4/R8 rdata", rdata, m_read(addr));
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [NUM_CH-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [NUM_CH-1:0] exp, input string req);
    addr = a; #1;
    check(rdata === exp, req, rdata, exp);
  endtask

  task automatic pulse(input int ch);
    err[ch] = 1'b1; tick(); err[ch] = 1'b0; tick();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd_chk(2'd0, '0, "R1 status");
    rd_chk(2'd1, '0, "R1 irq_en");
    rd_chk(2'd2, '0, "R1 pin_en");
    check(irq === 1'b0 && pin_n === 1'b1, "R1 outputs", {30'd0, irq, pin_n}, 32'd1);

    // R3: set with no responses enabled
    pulse(26);
    rd_chk(2'd0, 32'h0400_0000, "R3 status set while disabled");
    check(irq === 1'b0 && pin_n === 1'b1, "R3 no response", {30'd0, irq, pin_n}, 32'd1);

    // R2/R10: held source sets once, stays sticky, no re-set after clear
    err[28] = 1'b1; tick(); tick(); tick();
    rd_chk(2'd0, 32'h1400_0000, "R2 held source sets");
    wr(2'd0, 32'h1000_0000);
    tick();
    rd_chk(2'd0, 32'h0400_0000, "R2 no re-set while held high");
    err[28] = 1'b0; tick();
    rd_chk(2'd0, 32'h0400_0000, "R10 sticky after source drop");

    // R4: zero write no effect, then multi-bit clear
    wr(2'd0, 32'h0);
    rd_chk(2'd0, 32'h0400_0000, "R4 zero write keeps");
    pulse(28);
    wr(2'd0, 32'h1400_0000);
    rd_chk(2'd0, 32'h0, "R4 clear 26 and 28");

    // R8: enables, reserved address
    wr(2'd1, 32'h0400_0001);
    wr(2'd2, 32'h1000_0001);
    wr(2'd3, 32'hFFFF_FFFF);
    rd_chk(2'd1, 32'h0400_0001, "R8 irq_en readback");
    rd_chk(2'd2, 32'h1000_0001, "R8 pin_en readback");
    rd_chk(2'd3, 32'h0, "R8 reserved reads 0");

    // R9: independent routing
    pulse(26);
    #1 check(irq === 1'b1 && pin_n === 1'b1, "R9 irq only", {30'd0, irq, pin_n}, 32'd3);
    pulse(28);
    #1 check(irq === 1'b1 && pin_n === 1'b0, "R9 pin added", {30'd0, irq, pin_n}, 32'd2);
    wr(2'd0, 32'h0400_0000);
    #1 check(irq === 1'b0 && pin_n === 1'b0, "R6 irq drops, R7 pin holds", {30'd0, irq, pin_n}, 32'd0);
    pulse(0);
    #1 check(irq === 1'b1 && pin_n === 1'b0, "R9 both on ch0", {30'd0, irq, pin_n}, 32'd2);
    wr(2'd0, 32'hFFFF_FFFF);
    #1 check(irq === 1'b0 && pin_n === 1'b1, "R7 pin released", {30'd0, irq, pin_n}, 32'd1);

    // R5: set and clear at the same edge
    err[5] = 1'b1; we = 1'b1; addr = 2'd0; wdata = 32'h0000_0020;
    tick(); err[5] = 1'b0;
    rd_chk(2'd0, 32'h0000_0020, "R5 set wins over clear");
    wr(2'd0, 32'h0000_0020);

    // random phase compared every cycle against the model
    for (int k = 0; k < 2000; k++) begin
      err   = $urandom() & $urandom() & $urandom();
      we    = ($urandom_range(0, 3) == 0);
      addr  = 2'($urandom_range(0, 3));
      wdata = $urandom();
      @(posedge clk); @(negedge clk);
    end
    we = 1'b0; err = '0;
    tick();
    finish_run();
  end
endmodule